// File: doc/BRIEF.md
# Packet CRC Checker and Regenerator

This block sits in the forwarding path of a serial packet link. Packets arrive as a stream of 16-bit words framed by start and end markers and leave in the same cycle they are accepted. The block follows each packet word by word and runs a CRC-16 over what it receives. It finds the embedded CRC fields and checks each one against the running value. A packet whose CRC fields disagree with the data is flagged on its last word.

A packet can hold up to two CRC fields. The final field is always the last word. A packet that extends past byte 80 also carries an intermediate field at byte offset 80. Ordinary packets leave with their CRC words untouched, so corruption picked up inside the device is still caught further downstream. Maintenance packets carry a hop counter that the block decrements. Because the hop counter lies under the CRC, every CRC word of a maintenance packet is rebuilt from the words that are actually sent.

The control is a three-state machine. ST_IDLE waits for a start marker. ST_SEG1 covers the words up to and including the intermediate CRC position. ST_SEG2 covers the words after an intermediate CRC. The transitions are:
- ST_IDLE to ST_SEG1 on a start word that is not also an end word.
- ST_SEG1 to ST_SEG2 on word index 40 when that word is not an end word.
- ST_SEG1 or ST_SEG2 back to ST_IDLE on any end word.

Top module: `pkt_crc_regen`

## Requirements
- R1: The CRC uses polynomial 0x1021 (x^16+x^12+x^5+1), starts at 0xFFFF for each packet, and folds in each word most significant bit first. Bits [15:10] of the first word are taken as zero for the CRC, so changing them never changes the check result.
- R2: A packet begins with a word accepted with in_sop high while no packet is open, and ends with the word carrying in_eop. Words accepted outside a packet are passed through unchanged and never raise out_err.
- R3: Word index 40 (byte offset 80, counting the first word as index 0) is an intermediate CRC field when it is not the end word. A packet whose end word has index 40 or lower carries only the final CRC, which is its end word.
- R4: The running CRC continues through the intermediate CRC word as received, so the final CRC covers that word as well.
- R5: out_err is high on the end word of a packet in which any received CRC field differed from the running CRC. It is low on every other word, and a new packet starts with no error.
- R6: For a packet that is not a maintenance packet, every output word equals its input word.
- R7: The first word holds the transport type in [7:6] and the format type in [3:0]. Format type 8 with transport type 0 puts the hop count in bits [15:8] of word index 3. Format type 8 with transport type 1 puts it in word index 4. Format type 8 with transport type 2 or 3 is forwarded as an ordinary packet.
- R8: In a maintenance packet the hop count is sent reduced by one. A hop count of zero is sent as zero.
- R9: In a maintenance packet each CRC word is replaced by the CRC of the words actually sent before it. This includes the rebuilt intermediate CRC.
- R10: out_valid equals in_valid and in_ready equals out_ready in the same cycle, with no added latency. A word is consumed only when in_valid and out_ready are both high, and stalls leave the results unchanged.
- R11: After reset the block waits for a start word, and any packet that was open is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take the input word |
| in_sop | input | 1 | Input word starts a packet |
| in_eop | input | 1 | Input word ends a packet |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_sop | output | 1 | Output word starts a packet |
| out_eop | output | 1 | Output word ends a packet |
| out_data | output | 16 | Output word, with hop count and CRC rewritten for maintenance packets |
| out_err | output | 1 | CRC error for the packet, valid on its end word |

## Verification
Every result is due in the cycle its input word is presented. This covers the forwarded word, the rewritten hop count, the rebuilt CRC word and the error flag on the end word. The registered CRC and word counter only affect words presented after the next accepting edge. The bench therefore drives each word after the falling edge and compares the outputs against its behavioural model a short time later, before the rising edge that consumes the word. While out_ready is low the same word is held and checked again on every clock, which shows that a stall does not advance the CRC or the word index.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned LINK_BITS = 6;
    localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [WORD_W-1:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEG1 = 2'd1,
        ST_SEG2 = 2'd2
    } seg_state_e;

    function automatic logic [WORD_W-1:0] mask_link(input logic [WORD_W-1:0] w);
        return {{LINK_BITS{1'b0}}, w[WORD_W-LINK_BITS-1:0]};
    endfunction

endpackage

// File: rtl/crc16_word.sv
module crc16_word
    import pkt_crc_pkg::*;
#(
    parameter logic [WORD_W-1:0] POLY = CRC_POLY
) (
    input  logic [WORD_W-1:0] crc_in,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] crc_out
);

    always_comb begin
        logic [WORD_W-1:0] c;
        logic              fb;
        c = crc_in;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            fb = c[WORD_W-1] ^ data[b];
            c  = {c[WORD_W-2:0], 1'b0};
            if (fb) begin
                c = c ^ POLY;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/maint_hdr_decode.sv
module maint_hdr_decode
    import pkt_crc_pkg::*;
#(
    parameter int unsigned MAINT_FTYPE   = 8,
    parameter int unsigned HOP_IDX_SMALL = 3,
    parameter int unsigned HOP_IDX_LARGE = 4,
    parameter int unsigned IDX_W         = 6
) (
    input  logic [WORD_W-1:0] hdr,
    output logic              is_maint,
    output logic [IDX_W-1:0]  hop_idx
);

    logic [1:0] tt_field;
    logic [3:0] ft_field;

    assign tt_field = hdr[7:6];
    assign ft_field = hdr[3:0];

    always_comb begin
        is_maint = 1'b0;
        hop_idx  = IDX_W'(HOP_IDX_SMALL);
        unique case (tt_field)
            2'd0: begin
                is_maint = (ft_field == 4'(MAINT_FTYPE));
                hop_idx  = IDX_W'(HOP_IDX_SMALL);
            end
            2'd1: begin
                is_maint = (ft_field == 4'(MAINT_FTYPE));
                hop_idx  = IDX_W'(HOP_IDX_LARGE);
            end
            default: begin
                is_maint = 1'b0;
                hop_idx  = IDX_W'(HOP_IDX_SMALL);
            end
        endcase
    end

endmodule

// File: rtl/pkt_crc_regen.sv
module pkt_crc_regen
    import pkt_crc_pkg::*;
#(
    parameter int unsigned MID_CRC_WORD  = 40,
    parameter int unsigned MAINT_FTYPE   = 8,
    parameter int unsigned HOP_IDX_SMALL = 3,
    parameter int unsigned HOP_IDX_LARGE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [WORD_W-1:0] out_data,
    output logic              out_err
);

    localparam int unsigned IDX_W   = $clog2(MID_CRC_WORD + 2);
    localparam logic [IDX_W-1:0] IDX_MID = IDX_W'(MID_CRC_WORD);
    localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(MID_CRC_WORD + 1);

    seg_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [WORD_W-1:0] rx_q, tx_q;
    logic              maint_q, err_q;
    logic [IDX_W-1:0]  hop_q;

    logic              fire, first, active;
    logic              dec_maint, maint_now;
    logic [IDX_W-1:0]  dec_hop, hop_now, cur_idx;
    logic              mid_pos, crc_pos, hop_pos, mismatch, err_now;
    logic [WORD_W-1:0] rx_cur, tx_cur, rx_next, tx_next;
    logic [WORD_W-1:0] rx_fold, tx_fold, word_out;
    logic [7:0]        hop_dec;

    maint_hdr_decode #(
        .MAINT_FTYPE  (MAINT_FTYPE),
        .HOP_IDX_SMALL(HOP_IDX_SMALL),
        .HOP_IDX_LARGE(HOP_IDX_LARGE),
        .IDX_W        (IDX_W)
    ) u_decode (
        .hdr     (in_data),
        .is_maint(dec_maint),
        .hop_idx (dec_hop)
    );

    crc16_word #(.POLY(CRC_POLY)) u_rx_crc (
        .crc_in (rx_cur),
        .data   (rx_fold),
        .crc_out(rx_next)
    );

    crc16_word #(.POLY(CRC_POLY)) u_tx_crc (
        .crc_in (tx_cur),
        .data   (tx_fold),
        .crc_out(tx_next)
    );

    // Position and packet context for the word on the input
    assign fire      = in_valid & out_ready;
    assign first     = (state_q == ST_IDLE) & in_sop;
    assign active    = (state_q != ST_IDLE) | in_sop;
    assign cur_idx   = first ? '0 : idx_q;
    assign maint_now = first ? dec_maint : maint_q;
    assign hop_now   = first ? dec_hop : hop_q;
    assign mid_pos   = (state_q == ST_SEG1) & (idx_q == IDX_MID) & ~in_eop;
    assign crc_pos   = active & (in_eop | mid_pos);
    assign hop_pos   = active & maint_now & ~crc_pos & (state_q == ST_SEG1) & (idx_q == hop_now);
    assign rx_cur    = first ? CRC_INIT : rx_q;
    assign tx_cur    = first ? CRC_INIT : tx_q;
    assign mismatch  = crc_pos & (in_data != rx_cur);
    assign err_now   = first ? 1'b0 : err_q;
    assign hop_dec   = (in_data[15:8] == 8'd0) ? 8'd0 : in_data[15:8] - 8'd1;
    assign rx_fold   = first ? mask_link(in_data) : in_data;
    assign tx_fold   = first ? mask_link(word_out) : word_out;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rx_q    <= CRC_INIT;
            tx_q    <= CRC_INIT;
            maint_q <= 1'b0;
            hop_q   <= '0;
            err_q   <= 1'b0;
        end else if (fire) begin
            state_q <= state_d;
            if (active) begin
                idx_q   <= idx_d;
                rx_q    <= rx_next;
                tx_q    <= tx_next;
                maint_q <= maint_now;
                hop_q   <= hop_now;
                err_q   <= err_now | mismatch;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = (cur_idx == IDX_SAT) ? cur_idx : cur_idx + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (in_sop && !in_eop) state_d = ST_SEG1;
            end
            ST_SEG1: begin
                if (in_eop)       state_d = ST_IDLE;
                else if (mid_pos) state_d = ST_SEG2;
            end
            ST_SEG2: begin
                if (in_eop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_sop   = in_sop;
        out_eop   = in_eop;
        word_out  = in_data;
        if (active && maint_now) begin
            if (crc_pos)      word_out = tx_cur;
            else if (hop_pos) word_out = {hop_dec, in_data[7:0]};
        end
        out_data = word_out;
        out_err  = in_valid & in_eop & active & (err_now | mismatch);
    end

    p_seg2_after_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && state_q == ST_SEG1 && idx_q == IDX_MID && !in_eop) |=> (state_q == ST_SEG2));

    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_SAT);

    p_idle_after_eop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && in_eop) |=> (state_q == ST_IDLE));

    p_transparent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && active && !maint_now) |-> (out_data == in_data));

    p_err_on_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (in_eop && out_valid));

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(rx_q) && $stable(tx_q) && $stable(state_q) && $stable(idx_q)));

endmodule

// File: tb/tb_pkt_crc_regen.sv
module tb_pkt_crc_regen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, in_sop, in_eop;
    logic [15:0] in_data;
    logic        out_valid, out_ready, out_sop, out_eop, out_err;
    logic [15:0] out_data;

    always #4 clk = ~clk;

    pkt_crc_regen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_sop  (out_sop),
        .out_eop  (out_eop),
        .out_data (out_data),
        .out_err  (out_err)
    );

    int          checks = 0;
    int          fails  = 0;
    logic [15:0] pkt[$];
    logic [15:0] exp_w[$];
    bit          exp_err;
    logic [7:0]  lf = 8'h5A;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] ^ d[b]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Fill every CRC position of pkt with a correct value
    task automatic seal();
        int n = pkt.size();
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            if (i == n - 1 || (i == 40 && n - 1 > 40)) pkt[i] = c;
            c = crc_step(c, (i == 0) ? (pkt[i] & 16'h03FF) : pkt[i]);
        end
    endtask

    task automatic make_pkt(input logic [1:0] tt, input logic [3:0] ft, input int n, input logic [7:0] hop);
        pkt.delete();
        pkt.push_back({6'b0, 2'b01, tt, 2'b00, ft});
        for (int i = 1; i < n; i++) pkt.push_back(16'(i * 16'h1357) ^ 16'hA5A5);
        if (n > 4) begin
            if (tt == 2'd1) pkt[4][15:8] = hop;
            else            pkt[3][15:8] = hop;
        end
        seal();
    endtask

    // Behavioural model of the output stream and error flag
    task automatic model();
        int n = pkt.size();
        bit maint = (pkt[0][3:0] == 4'd8) && (pkt[0][7:6] <= 2'd1);
        int hop = (pkt[0][7:6] == 2'd1) ? 4 : 3;
        logic [15:0] rx = 16'hFFFF, tx = 16'hFFFF, o;
        exp_w.delete();
        exp_err = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit is_crc = (i == n - 1) || (i == 40 && n - 1 > 40);
            o = pkt[i];
            if (is_crc) begin
                if (pkt[i] != rx) exp_err = 1'b1;
                if (maint) o = tx;
            end else if (maint && i == hop) begin
                o[15:8] = (pkt[i][15:8] == 8'd0) ? 8'd0 : pkt[i][15:8] - 8'd1;
            end
            exp_w.push_back(o);
            rx = crc_step(rx, (i == 0) ? (pkt[i] & 16'h03FF) : pkt[i]);
            tx = crc_step(tx, (i == 0) ? (o & 16'h03FF) : o);
        end
    endtask

    task automatic send_word(input logic [15:0] d, input bit sop, input bit eop,
                             input logic [15:0] ed, input bit ee, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_eop = eop; in_data = d;
        forever begin
            out_ready = lf[0] | lf[2];
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            #2;
            check(out_valid == 1'b1 && in_ready == out_ready, {tag, " R10 flow"},
                  {out_valid, in_ready}, {1'b1, out_ready});
            check(out_data == ed, {tag, " data"}, out_data, ed);
            check(out_err == ee, {tag, " err R5"}, out_err, ee);
            check(out_sop == sop && out_eop == eop, {tag, " markers R2"}, {out_sop, out_eop}, {sop, eop});
            if (out_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; out_ready = 1'b1;
        #2;
        check(out_valid == 1'b0 && out_err == 1'b0, "R10 idle", {out_valid, out_err}, 0);
    endtask

    task automatic send_pkt(input string tag);
        int n = pkt.size();
        model();
        for (int i = 0; i < n; i++)
            send_word(pkt[i], i == 0, i == n - 1, exp_w[i], (i == n - 1) ? exp_err : 1'b0, tag);
        idle_cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_data = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && out_err == 1'b0, "R11 reset state", {out_valid, out_err}, 0);
        rst_n = 1'b1;

        // R1 R6: short ordinary packet
        make_pkt(2'd0, 4'd5, 10, 8'h00);
        send_pkt("R1 R6 short ordinary");

        // R5: corrupted final CRC, then a clean packet starts fresh
        make_pkt(2'd0, 4'd5, 10, 8'h00);
        pkt[9] ^= 16'h0100;
        send_pkt("R5 bad final crc");
        check(exp_err == 1'b1, "R5 model flags", exp_err, 1);
        make_pkt(2'd1, 4'd2, 12, 8'h00);
        send_pkt("R5 fresh packet");

        // R3 R4: long packet with intermediate CRC
        make_pkt(2'd0, 4'd6, 60, 8'h00);
        send_pkt("R3 R4 long ordinary");

        // R3: bad intermediate CRC only (final resealed over bad value)
        make_pkt(2'd0, 4'd6, 60, 8'h00);
        pkt[40] ^= 16'h0001;
        begin
            logic [15:0] c = 16'hFFFF;
            for (int i = 0; i < 59; i++) c = crc_step(c, (i == 0) ? (pkt[i] & 16'h03FF) : pkt[i]);
            pkt[59] = c;
        end
        send_pkt("R3 R4 bad intermediate");

        // R3: boundary lengths, end word at index 39, 40, 41
        make_pkt(2'd0, 4'd6, 40, 8'h00);
        send_pkt("R3 end idx 39");
        make_pkt(2'd0, 4'd6, 41, 8'h00);
        send_pkt("R3 end idx 40");
        make_pkt(2'd0, 4'd6, 42, 8'h00);
        send_pkt("R3 end idx 41");

        // R7 R8 R9: maintenance packets
        make_pkt(2'd0, 4'd8, 50, 8'h05);
        send_pkt("R7 R8 R9 maint small");
        make_pkt(2'd1, 4'd8, 20, 8'h00);
        send_pkt("R7 R8 R9 maint large hop zero");
        make_pkt(2'd1, 4'd8, 45, 8'hFF);
        send_pkt("R7 R9 maint large long");
        make_pkt(2'd2, 4'd8, 20, 8'h07);
        send_pkt("R7 R6 undecoded transport");

        // R9 R5: bad input CRC on a maintenance packet
        make_pkt(2'd0, 4'd8, 15, 8'h09);
        pkt[14] ^= 16'h8000;
        send_pkt("R9 R5 maint bad crc");

        // R1: link bits ignored by the CRC
        make_pkt(2'd0, 4'd5, 16, 8'h00);
        pkt[0][15:10] = 6'b101101;
        send_pkt("R1 link bits ignored");

        // R2: words outside any packet
        send_word(16'hBEEF, 1'b0, 1'b0, 16'hBEEF, 1'b0, "R2 stray word");
        send_word(16'h1234, 1'b0, 1'b1, 16'h1234, 1'b0, "R2 stray end word");
        idle_cycle();

        // R11: reset during a maintenance packet abandons it
        make_pkt(2'd0, 4'd8, 30, 8'h03);
        model();
        for (int i = 0; i < 6; i++) send_word(pkt[i], i == 0, 1'b0, exp_w[i], 1'b0, "R11 partial");
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        make_pkt(2'd0, 4'd5, 12, 8'h00);
        send_pkt("R11 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule